// File: doc/BRIEF.md
# Serial Display Character Loader

This block sits on the host side of a serial LED matrix display and turns one request into the framed serial traffic that the display expects. A request either writes a whole character or sends a single control word. A character request carries a character position and five 5-bit row patterns. A control request carries five bits of control data. The block sends the traffic on three wires: an active-low load strobe, a serial clock and a data line.

Every 8-bit word goes out in its own frame. The load strobe drops, and eight clock pulses shift the word out least significant bit first. The strobe then rises again. The block keeps the strobe high for at least a programmed idle time before the next word. That time is given in nanoseconds and is rounded up to whole system-clock cycles. Each word puts a 3-bit code in its top three bits and five data bits below it. The requester sees `busy_o` for the whole transfer and a one-cycle `done_o` at its end. A new request is taken only when the block is idle.

Top module: `glyph_link_tx`

## Requirements
- R1: A character request sends the position word first: bits 7..5 = 101, bits 4..3 = 00, bits 2..0 = the requested position.
- R2: After the position word come five row words, for rows 0 to 4 in order. In the word for row r, bits 7..5 hold r (000 to 100) and bits 4..0 hold `req_rows_i[5r+4:5r]`.
- R3: A control request sends exactly one word: bits 7..5 = 110 and bits 4..0 = `req_ctrl_data_i`.
- R4: Each word is framed by one low period of `load_n_o`. Within that period, `sdclk_o` rises exactly eight times, and the bit on `sdata_o` at the k-th rise is word bit k-1, starting from bit 0.
- R5: `sdclk_o` is low whenever `load_n_o` is high, and `sdata_o` never changes while `sdclk_o` is high.
- R6: Between any two words, `load_n_o` stays high for at least GAP = ceil(MIN_GAP_NS*1000 / SYS_CLK_PS) system-clock cycles.
- R7: Each high phase of `sdclk_o` lasts exactly SCLK_HALF_CYC system-clock cycles.
- R8: `busy_o` is high from the cycle after an accepted request until the transfer ends. `done_o` is high for exactly one cycle, and that is the first cycle in which `busy_o` is low again.
- R9: A request presented while `busy_o` is high has no effect. No extra word is sent and no extra `done_o` occurs.
- R10: Out of reset, `load_n_o` is high and `sdclk_o`, `sdata_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken only while idle |
| req_ctrl_i | input | 1 | 1 = control word request, 0 = character request |
| req_pos_i | input | 3 | Character position |
| req_rows_i | input | 25 | Row patterns, row r at bits 5r+4..5r |
| req_ctrl_data_i | input | 5 | Control word data bits |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| load_n_o | output | 1 | Active-low word frame strobe |
| sdclk_o | output | 1 | Serial clock; the display samples on its rising edge |
| sdata_o | output | 1 | Serial data, LSB first |

## Verification
The bench sweeps every position, with varied row patterns and with all-zero and all-one rows, and every control value. It rebuilds each word from the serial pins and compares it with words built from the request. A design that sent the bits MSB first, put the row number in the wrong field or dropped the sixth word would show up as a wrong word or a wrong word count. The idle time is configured so that the nanosecond-to-cycle conversion is not exact. A design that rounded down would show one cycle too few with the strobe high. The bench also measures every clock high phase and checks that data holds still while the clock is high. A second request is issued in the middle of a transfer, so a design that took it would send extra words or pulse `done_o` twice.

// File: rtl/glyph_link_pkg.sv
package glyph_link_pkg;

  localparam int COLS   = 5;
  localparam int ROWS   = 5;
  localparam int POS_W  = 3;
  localparam int OPC_W  = 3;
  localparam int WORD_W = OPC_W + COLS;
  localparam int IDX_W  = $clog2(ROWS + 1);

  localparam logic [OPC_W-1:0] OPC_POSITION = 3'b101;
  localparam logic [OPC_W-1:0] OPC_CONTROL  = 3'b110;

  typedef enum logic [1:0] {
    Q_IDLE,
    Q_ISSUE,
    Q_SEND,
    Q_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_TAIL
  } sh_state_t;

  function automatic logic [WORD_W-1:0] pack_word(input logic [OPC_W-1:0] opc,
                                                  input logic [COLS-1:0]  dat);
    return {opc, dat};
  endfunction

endpackage

// File: rtl/glk_gap_timer.sv
module glk_gap_timer #(
  parameter int GAP_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(GAP_CYC + 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_o = run_q && (cnt_q == '0);
    if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = CW'(GAP_CYC - 1);
      cnt_en = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/glk_byte_shifter.sv
module glk_byte_shifter
  import glyph_link_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_n_o,
  output logic              sdclk_o,
  output logic              sdata_o,
  output logic              done_o
);
  localparam int HW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  sh_state_t         st_q, st_d;
  logic [HW-1:0]     hcnt_q, hcnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              ld_n_q, ld_n_d;
  logic              sck_q, sck_d;
  logic              sd_q, sd_d;
  logic              done_q, done_d;
  logic              half_end;

  assign half_end = (hcnt_q == '0);

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    bit_d  = bit_q;
    sreg_d = sreg_q;
    ld_n_d = ld_n_q;
    sck_d  = sck_q;
    sd_d   = sd_q;
    done_d = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (start_i) begin
          st_d   = SH_LOW;
          sreg_d = word_i;
          bit_d  = '0;
          ld_n_d = 1'b0;
          sck_d  = 1'b0;
          sd_d   = word_i[0];
          hcnt_d = HW'(HALF_CYC - 1);
        end
      end
      SH_LOW: begin
        if (half_end) begin
          st_d   = SH_HIGH;
          sck_d  = 1'b1;
          hcnt_d = HW'(HALF_CYC - 1);
        end else begin
          hcnt_d = hcnt_q - 1'b1;
        end
      end
      SH_HIGH: begin
        if (half_end) begin
          sck_d  = 1'b0;
          hcnt_d = HW'(HALF_CYC - 1);
          if (bit_q == BIT_W'(WORD_W - 1)) begin
            st_d = SH_TAIL;
          end else begin
            st_d  = SH_LOW;
            bit_d = bit_q + 1'b1;
            sd_d  = sreg_q[bit_q + 1'b1];
          end
        end else begin
          hcnt_d = hcnt_q - 1'b1;
        end
      end
      SH_TAIL: begin
        if (half_end) begin
          st_d   = SH_IDLE;
          ld_n_d = 1'b1;
          done_d = 1'b1;
        end else begin
          hcnt_d = hcnt_q - 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      hcnt_q <= '0;
      bit_q  <= '0;
      sreg_q <= '0;
      ld_n_q <= 1'b1;
      sck_q  <= 1'b0;
      sd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      bit_q  <= bit_d;
      sreg_q <= sreg_d;
      ld_n_q <= ld_n_d;
      sck_q  <= sck_d;
      sd_q   <= sd_d;
      done_q <= done_d;
    end
  end

  assign load_n_o = ld_n_q;
  assign sdclk_o  = sck_q;
  assign sdata_o  = sd_q;
  assign done_o   = done_q;

endmodule

// File: rtl/glk_frame_seq.sv
module glk_frame_seq
  import glyph_link_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic                 req_ctrl_i,
  input  logic [POS_W-1:0]     req_pos_i,
  input  logic [ROWS*COLS-1:0] req_rows_i,
  input  logic [COLS-1:0]      req_ctrl_data_i,
  output logic                 shift_start_o,
  output logic [WORD_W-1:0]    shift_word_o,
  input  logic                 shift_done_i,
  output logic                 gap_start_o,
  input  logic                 gap_done_i,
  output logic                 busy_o,
  output logic                 done_o
);
  seq_state_t           st_q, st_d;
  logic [IDX_W-1:0]     widx_q, widx_d;
  logic [IDX_W-1:0]     last_q;
  logic                 ctrl_q;
  logic [POS_W-1:0]     pos_q;
  logic [ROWS*COLS-1:0] rows_q;
  logic [COLS-1:0]      cdat_q;
  logic                 done_q, done_d;
  logic                 accept;
  logic [WORD_W-1:0]    row_word [ROWS];
  logic [WORD_W-1:0]    pos_word;

  assign accept = (st_q == Q_IDLE) && req_valid_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row_word
    assign row_word[r] = pack_word(OPC_W'(r), rows_q[r*COLS +: COLS]);
  end

  assign pos_word = pack_word(OPC_POSITION, {{(COLS-POS_W){1'b0}}, pos_q});

  always_comb begin
    shift_word_o = pos_word;
    if (ctrl_q) begin
      shift_word_o = pack_word(OPC_CONTROL, cdat_q);
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (int'(widx_q) == r + 1) shift_word_o = row_word[r];
      end
    end
  end

  always_comb begin
    st_d          = st_q;
    widx_d        = widx_q;
    done_d        = 1'b0;
    shift_start_o = 1'b0;
    gap_start_o   = 1'b0;
    unique case (st_q)
      Q_IDLE: begin
        if (accept) begin
          st_d   = Q_ISSUE;
          widx_d = '0;
        end
      end
      Q_ISSUE: begin
        shift_start_o = 1'b1;
        st_d          = Q_SEND;
      end
      Q_SEND: begin
        if (shift_done_i) begin
          gap_start_o = 1'b1;
          st_d        = Q_GAP;
        end
      end
      Q_GAP: begin
        if (gap_done_i) begin
          if (widx_q == last_q) begin
            st_d   = Q_IDLE;
            done_d = 1'b1;
          end else begin
            st_d   = Q_ISSUE;
            widx_d = widx_q + 1'b1;
          end
        end
      end
      default: st_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= Q_IDLE;
      widx_q <= '0;
      done_q <= 1'b0;
      last_q <= '0;
      ctrl_q <= 1'b0;
      pos_q  <= '0;
      rows_q <= '0;
      cdat_q <= '0;
    end else begin
      st_q   <= st_d;
      widx_q <= widx_d;
      done_q <= done_d;
      if (accept) begin
        last_q <= req_ctrl_i ? '0 : IDX_W'(ROWS);
        ctrl_q <= req_ctrl_i;
        pos_q  <= req_pos_i;
        rows_q <= req_rows_i;
        cdat_q <= req_ctrl_data_i;
      end
    end
  end

  assign busy_o = (st_q != Q_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/glyph_link_tx.sv
module glyph_link_tx
  import glyph_link_pkg::*;
#(
  parameter int SYS_CLK_PS    = 8000,
  parameter int MIN_GAP_NS    = 600,
  parameter int SCLK_HALF_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic                 req_ctrl_i,
  input  logic [POS_W-1:0]     req_pos_i,
  input  logic [ROWS*COLS-1:0] req_rows_i,
  input  logic [COLS-1:0]      req_ctrl_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 load_n_o,
  output logic                 sdclk_o,
  output logic                 sdata_o
);
  localparam int GAP_RAW = (MIN_GAP_NS * 1000 + SYS_CLK_PS - 1) / SYS_CLK_PS;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

  logic              shift_start, shift_done;
  logic [WORD_W-1:0] shift_word;
  logic              gap_start, gap_done;

  glk_frame_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_ctrl_i     (req_ctrl_i),
    .req_pos_i      (req_pos_i),
    .req_rows_i     (req_rows_i),
    .req_ctrl_data_i(req_ctrl_data_i),
    .shift_start_o  (shift_start),
    .shift_word_o   (shift_word),
    .shift_done_i   (shift_done),
    .gap_start_o    (gap_start),
    .gap_done_i     (gap_done),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  glk_byte_shifter #(.HALF_CYC(SCLK_HALF_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (shift_start),
    .word_i  (shift_word),
    .load_n_o(load_n_o),
    .sdclk_o (sdclk_o),
    .sdata_o (sdata_o),
    .done_o  (shift_done)
  );

  glk_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(gap_start),
    .done_o (gap_done)
  );

endmodule

// File: rtl/glk_checker.sv
module glk_checker #(
  parameter int GAP_CYC = 75
) (
  input logic clk,
  input logic rst_n,
  input logic load_n,
  input logic sdclk,
  input logic sdata,
  input logic busy,
  input logic done
);
  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] hi_cnt;
  logic [3:0]    rise_cnt;
  logic          sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= CW'(GAP_CYC);
      rise_cnt <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sdclk;
      if (!load_n) hi_cnt <= '0;
      else if (hi_cnt != CW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (load_n) rise_cnt <= '0;
      else if (sdclk && !sck_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r5_clk_low_when_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |-> !sdclk);

  a_r5_data_holds_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sdclk && $past(sdclk)) |-> $stable(sdata));

  a_r6_min_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> (hi_cnt >= CW'(GAP_CYC)));

  a_r4_eight_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_n) |-> (rise_cnt == 4'd8));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind glyph_link_tx glk_checker #(.GAP_CYC(GAP_CYC)) u_glk_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .load_n(load_n_o),
  .sdclk (sdclk_o),
  .sdata (sdata_o),
  .busy  (busy_o),
  .done  (done_o)
);

// File: tb/test_glyph_link_tx.sv
module test_glyph_link_tx;
  localparam int SYS_PS = 8000;
  localparam int GAP_NS = 603;
  localparam int HALF   = 2;
  localparam int GAP_EXP = (GAP_NS * 1000 + SYS_PS - 1) / SYS_PS;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ctrl;
  logic [2:0]  req_pos;
  logic [24:0] req_rows;
  logic [4:0]  req_cdat;
  logic        busy, done, load_n, sdclk, sdata;

  int checks, failures, cycles;

  glyph_link_tx #(.SYS_CLK_PS(SYS_PS), .MIN_GAP_NS(GAP_NS), .SCLK_HALF_CYC(HALF)) i_glyph_link_tx (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ctrl_i(req_ctrl),
    .req_pos_i(req_pos), .req_rows_i(req_rows), .req_ctrl_data_i(req_cdat),
    .busy_o(busy), .done_o(done), .load_n_o(load_n), .sdclk_o(sdclk), .sdata_o(sdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial monitor, sampled on falling edges
  logic [7:0] got [0:15];
  int   got_n, nbits, hi_cnt, sck_hi;
  logic [7:0] cur;
  logic prev_sck, prev_ld, prev_sd;
  int   done_seen;

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      got_n <= 0; nbits = 0; hi_cnt = 1000; sck_hi = 0;
      prev_sck = 0; prev_ld = 1; prev_sd = 0; cur = '0;
    end else begin
      if (done) done_seen++;
      if (load_n && sdclk) chk(0, "R5 clock high while unloaded", 1, 0);
      if (sdclk && prev_sck) chk(sdata == prev_sd, "R5 data moved in high phase", int'(sdata), int'(prev_sd));
      if (!load_n && sdclk && !prev_sck) begin
        cur = {sdata, cur[7:1]};
        nbits++;
      end
      if (sdclk) sck_hi++;
      else if (prev_sck) begin
        chk(sck_hi == HALF, "R7 high phase length", sck_hi, HALF);
        sck_hi = 0;
      end
      if (load_n && !prev_ld) begin
        chk(nbits == 8, "R4 pulses per frame", nbits, 8);
        if (got_n < 16) got[got_n] = cur;
        got_n++;
        hi_cnt = 1;
      end else if (load_n) hi_cnt++;
      if (!load_n && prev_ld) begin
        chk(hi_cnt >= GAP_EXP, "R6 idle between words", hi_cnt, GAP_EXP);
        nbits = 0;
      end
      prev_sck = sdclk; prev_ld = load_n; prev_sd = sdata;
    end
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_req(input bit ctl, input logic [2:0] pos, input logic [24:0] rows,
                         input logic [4:0] cd, input bit poke_busy);
    logic [7:0] exp_w [0:5];
    int n_exp, waitc, d0;
    n_exp = ctl ? 1 : 6;
    if (ctl) exp_w[0] = {3'b110, cd};
    else begin
      exp_w[0] = {3'b101, 2'b00, pos};
      for (int r = 0; r < 5; r++) exp_w[r+1] = {3'(r), rows[5*r +: 5]};
    end
    got_n = 0;
    d0 = done_seen;
    req_valid = 1; req_ctrl = ctl; req_pos = pos; req_rows = rows; req_cdat = cd;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    if (poke_busy) begin
      repeat (60) @(negedge clk);
      req_valid = 1; req_ctrl = ~ctl; req_pos = ~pos; req_rows = ~rows; req_cdat = ~cd;
      @(negedge clk);
      req_valid = 0;
    end
    waitc = 0;
    while (!done && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, "R8 done arrives", int'(done), 1);
    chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    if (poke_busy) repeat (300) @(negedge clk);
    chk(got_n == n_exp, poke_busy ? "R9 word count" : "R2 R3 word count", got_n, n_exp);
    chk(done_seen - d0 == 1, poke_busy ? "R9 done count" : "R8 done count", done_seen - d0, 1);
    for (int i = 0; i < n_exp && i < got_n; i++) begin
      if (ctl) chk(got[i] == exp_w[i], "R3 control word", int'(got[i]), int'(exp_w[i]));
      else if (i == 0) chk(got[i] == exp_w[i], "R1 position word", int'(got[i]), int'(exp_w[i]));
      else chk(got[i] == exp_w[i], "R2 row word", int'(got[i]), int'(exp_w[i]));
    end
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; done_seen = 0;
    req_valid = 0; req_ctrl = 0; req_pos = '0; req_rows = '0; req_cdat = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(load_n == 1'b1, "R10 load reset", int'(load_n), 1);
    chk({sdclk, sdata, busy, done} == 4'b0, "R10 outputs reset", int'({sdclk, sdata, busy, done}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      logic [24:0] rw;
      for (int r = 0; r < 5; r++) rw[5*r +: 5] = 5'((p * 7 + r * 13 + 5) % 32);
      run_req(0, 3'(p), rw, 5'd0, 0);
    end
    run_req(0, 3'd0, 25'h0, 5'd0, 0);
    run_req(0, 3'd7, 25'h1FFFFFF, 5'd0, 0);
    for (int c = 0; c < 32; c++) run_req(1, 3'd0, 25'h0, 5'(c), 0);
    run_req(0, 3'd3, 25'h0A5C3E1, 5'd0, 1);
    run_req(1, 3'd0, 25'h0, 5'h15, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule